// File: doc/BRIEF.md
# Per-Pin Drive Mode Register Bank

This block keeps a drive mode for every pin of a group of 8-pin ports and hands each pin's mode to the pad-control logic as a 3-bit code. Software sees seven mode registers, one per drive mode, and each register has one bit per pin. A port-select register picks which port those seven registers act on. A pin always has exactly one mode. Writing a 1 to a pin's bit in any mode register moves that pin into that mode, which also removes it from the other six registers.

Each pin's state is a single 3-bit code, so the most recent write that set a pin always decides its mode. A read of a mode register is worked out from the stored codes. It returns the mode each pin holds now, not the data that was last written to that register.

Reads and writes use a plain synchronous register port with separate read and write addresses. A write takes effect at the clock edge where `wr_en` is high. A read returns its data one cycle after `rd_en`, together with a one-cycle `rd_valid` pulse. The port has no back-pressure: every request is accepted in the cycle it is presented. The bus front end and the analog pad behaviour are outside this block.

Top module: `dm_bank`

## Requirements
- R1: After reset every pin holds code 0 (resistive pull-up), the port-select register reads 00h, and the pull-up register (1Dh) reads FFh for port 0.
- R2: The mode registers sit at 1Dh + k for k = 0..6, with codes 0 pull-up, 1 pull-down, 2 open-drain high, 3 open-drain low, 4 strong fast, 5 strong slow and 6 high impedance. A write with bit i set to register 1Dh + k gives pin i of the selected port code k on `pin_mode` from the next cycle.
- R3: A 0 bit in a mode-register write leaves that pin's code unchanged, and a cycle without `wr_en` changes no code.
- R4: When two registers set the same pin one after the other, the later write decides the pin's mode. The earlier register then reads 0 at that pin.
- R5: Reading register 1Dh + k returns bit i = 1 exactly when pin i of the selected port holds code k.
- R6: Address 18h holds the port select and reads back the byte last written there. Mode-register writes change only the selected port.
- R7: While the port select is not below NUM_PORTS, mode-register writes change nothing and mode-register reads return 00h.
- R8: `rd_data` and `rd_valid` appear the cycle after `rd_en`, and `rd_valid` is low in a cycle that follows no read. Writes to unmapped addresses have no effect, and reads of unmapped addresses return 00h.
- R9: A single write with several 1 bits sets every one of those pins to that register's mode.
- R10: Every pin code on `pin_mode` is always one of the seven legal codes (never 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a result |
| pin_mode | output | NUM_PORTS*8*3 | 3-bit mode code per pin; pin i of port p is at bits (p*8+i)*3 +: 3 |

## Verification
Writes use a single bit, several scattered bits (A5h) and all-zero data. These separate per-bit updates from whole-register loads, and show whether 0 bits are wrongly treated as clears. A pin is set by one register and then by another, which checks that the later write decides and that the earlier register's readback drops the pin. Further writes go to a second port, to an out-of-range port select and to an unmapped address; these show that updates reach only the selected port and that ignored accesses change neither the pins nor the readback.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 7;

  typedef enum logic [MODE_W-1:0] {
    MODE_PULLUP = 3'd0,
    MODE_PULLDN = 3'd1,
    MODE_ODHI   = 3'd2,
    MODE_ODLO   = 3'd3,
    MODE_STRONG = 3'd4,
    MODE_SLOW   = 3'd5,
    MODE_HIZ    = 3'd6
  } drv_mode_e;
endpackage

// File: rtl/dm_addr_dec.sv
module dm_addr_dec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] MODE_BASE = 8'h1D
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit_sel,
  output logic                       hit_mode,
  output logic [dm_pkg::MODE_W-1:0]  mode_idx
);
  import dm_pkg::*;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - MODE_BASE;
    hit_sel  = (addr == SEL_ADDR);
    hit_mode = (addr >= MODE_BASE) && (offset < ADDR_W'(NUM_MODES));
    mode_idx = offset[MODE_W-1:0];
  end
endmodule

// File: rtl/dm_pin_cell.sv
module dm_pin_cell (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [dm_pkg::MODE_W-1:0]  set_code,
  output logic [dm_pkg::MODE_W-1:0]  code
);
  import dm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code <= MODE_PULLUP;
    else if (set_en)
      code <= set_code;
  end
endmodule

// File: rtl/dm_port_read.sv
module dm_port_read #(
  parameter int PORT_W = 8
) (
  input  logic [PORT_W*dm_pkg::MODE_W-1:0] codes,
  input  logic [dm_pkg::MODE_W-1:0]        mode_idx,
  output logic [PORT_W-1:0]                bits
);
  import dm_pkg::*;

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign bits[i] = (codes[i*MODE_W +: MODE_W] == mode_idx);
  end
endmodule

// File: rtl/dm_bank.sv
module dm_bank #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] MODE_BASE = 8'h1D
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [PORT_W-1:0]                     wr_data,
  input  logic                                  rd_en,
  input  logic [ADDR_W-1:0]                     rd_addr,
  output logic [PORT_W-1:0]                     rd_data,
  output logic                                  rd_valid,
  output logic [NUM_PORTS*PORT_W*dm_pkg::MODE_W-1:0] pin_mode
);
  import dm_pkg::*;

  localparam int PORT_BITS = PORT_W * MODE_W;
  localparam int NUM_PINS  = NUM_PORTS * PORT_W;

  logic [PORT_W-1:0] sel_q;
  logic              sel_ok;

  logic              w_hit_sel, w_hit_mode;
  logic [MODE_W-1:0] w_idx;
  logic              r_hit_sel, r_hit_mode;
  logic [MODE_W-1:0] r_idx;

  logic [PORT_BITS-1:0] sel_codes;
  logic [PORT_W-1:0]    sel_bits;
  logic [PORT_W-1:0]    rd_next;

  dm_addr_dec #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .MODE_BASE(MODE_BASE)) u_wdec (
    .addr(wr_addr), .hit_sel(w_hit_sel), .hit_mode(w_hit_mode), .mode_idx(w_idx)
  );

  dm_addr_dec #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .MODE_BASE(MODE_BASE)) u_rdec (
    .addr(rd_addr), .hit_sel(r_hit_sel), .hit_mode(r_hit_mode), .mode_idx(r_idx)
  );

  assign sel_ok = (32'(sel_q) < NUM_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (wr_en && w_hit_sel)
      sel_q <= wr_data;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_en && w_hit_mode && sel_ok && (32'(sel_q) == p);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      dm_pin_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (port_wr && wr_data[i]),
        .set_code (w_idx),
        .code     (pin_mode[(p*PORT_W+i)*MODE_W +: MODE_W])
      );
    end
  end

  always_comb begin
    sel_codes = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (32'(sel_q) == p)
        sel_codes = pin_mode[p*PORT_BITS +: PORT_BITS];
    end
  end

  dm_port_read #(.PORT_W(PORT_W)) u_read (
    .codes(sel_codes), .mode_idx(r_idx), .bits(sel_bits)
  );

  always_comb begin
    if (r_hit_sel)
      rd_next = sel_q;
    else if (r_hit_mode && sel_ok)
      rd_next = sel_bits;
    else
      rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= rd_next;
    end
  end

  initial begin
    if (NUM_PINS < 1 || NUM_PORTS > 8)
      $error("dm_bank: NUM_PORTS must be 1..8");
  end
endmodule

// File: rtl/dm_bank_chk.sv
module dm_bank_chk #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] MODE_BASE = 8'h1D
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  wr_en,
  input logic [ADDR_W-1:0]                     wr_addr,
  input logic [PORT_W-1:0]                     wr_data,
  input logic                                  rd_en,
  input logic [ADDR_W-1:0]                     rd_addr,
  input logic [PORT_W-1:0]                     rd_data,
  input logic                                  rd_valid,
  input logic [NUM_PORTS*PORT_W*dm_pkg::MODE_W-1:0] pin_mode
);
  import dm_pkg::*;

  logic [PORT_W-1:0] sel_sh;
  logic              w_mode, r_mode, bad_sel;
  logic [ADDR_W-1:0] w_off;
  logic [MODE_W-1:0] w_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_sh <= '0;
    else if (wr_en && wr_addr == SEL_ADDR)
      sel_sh <= wr_data;
  end

  always_comb begin
    w_off   = wr_addr - MODE_BASE;
    w_code  = w_off[MODE_W-1:0];
    w_mode  = (wr_addr >= MODE_BASE) && (w_off < ADDR_W'(NUM_MODES));
    r_mode  = (rd_addr >= MODE_BASE) && ((rd_addr - MODE_BASE) < ADDR_W'(NUM_MODES));
    bad_sel = !(32'(sel_sh) < NUM_PORTS);
  end

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R8
  AST_RD_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R8
  AST_IDLE_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(pin_mode)); // R3
  AST_BAD_SEL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && w_mode && bad_sel) |=> $stable(pin_mode)); // R7
  AST_BAD_SEL_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && r_mode && bad_sel) |=> (rd_data == '0)); // R7

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    for (genvar i = 0; i < PORT_W; i++) begin : g_i
      AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pin_mode[(p*PORT_W+i)*MODE_W +: MODE_W] != 3'd7); // R10
      AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_mode && 32'(sel_sh) == p && wr_data[i]) |=> (pin_mode[(p*PORT_W+i)*MODE_W +: MODE_W] == $past(w_code))); // R2
    end
  end
endmodule

bind dm_bank dm_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
  .SEL_ADDR(SEL_ADDR), .MODE_BASE(MODE_BASE)
) u_chk (.*);

// File: tb/sim_dm_bank.sv
module sim_dm_bank;
  localparam int NP = 3;
  localparam int PW = 8;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [NP*PW*MW-1:0] pin_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int exp_code [NP][PW];
  int exp_sel = 0;

  always #10 clk = ~clk;

  dm_bank #(.NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_mode(pin_mode)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h18) exp_sel = int'(d);
    else if (a >= 8'h1D && a <= 8'h23 && exp_sel < NP)
      for (int i = 0; i < PW; i++)
        if (d[i]) exp_code[exp_sel][i] = int'(a) - 'h1D;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8", "rd_valid after read", int'(rd_valid), 1);
    d = rd_data;
  endtask

  function automatic int exp_read(int a);
    int v = 0;
    if (a == 'h18) return exp_sel & 'hFF;
    if (a < 'h1D || a > 'h23 || exp_sel >= NP) return 0;
    for (int i = 0; i < PW; i++)
      if (exp_code[exp_sel][i] == a - 'h1D) v |= (1 << i);
    return v;
  endfunction

  task automatic check_pins(string req);
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PW; i++)
        chk(req, $sformatf("pin_mode p%0d i%0d", p, i),
            int'(pin_mode[(p*PW+i)*MW +: MW]), exp_code[p][i]);
  endtask

  task automatic check_read(string req, logic [7:0] a);
    logic [7:0] d;
    bus_read(a, d);
    chk(req, $sformatf("read %0h", a), int'(d), exp_read(int'(a)));
  endtask

  task automatic t_reset;
    check_pins("R1");
    check_read("R1", 8'h18);
    check_read("R1", 8'h1D);
    chk("R1", "pull-up readback", exp_read('h1D), 'hFF);
    check_read("R1", 8'h21);
  endtask

  task automatic t_single;
    bus_write(8'h21, 8'h01);
    chk("R2", "pin0 strong fast", int'(pin_mode[2:0]), 4);
    check_pins("R2");
    check_read("R5", 8'h21);
    check_read("R5", 8'h1D);
  endtask

  task automatic t_zero_bits;
    bus_write(8'h23, 8'h00);
    check_pins("R3");
    check_read("R3", 8'h23);
  endtask

  task automatic t_last_wins;
    bus_write(8'h23, 8'h01);
    chk("R4", "pin0 hiz", int'(pin_mode[2:0]), 6);
    check_read("R4", 8'h21);
    check_read("R4", 8'h23);
  endtask

  task automatic t_multi;
    bus_write(8'h1E, 8'hA5);
    check_pins("R9");
    check_read("R9", 8'h1E);
    check_read("R5", 8'h23);
    check_read("R5", 8'h1D);
  endtask

  task automatic t_port_sel;
    bus_write(8'h18, 8'h02);
    bus_write(8'h1F, 8'h0F);
    check_pins("R6");
    check_read("R6", 8'h18);
    check_read("R6", 8'h1F);
    check_read("R6", 8'h1E);
    bus_write(8'h18, 8'h01);
    bus_write(8'h22, 8'hF0);
    check_pins("R6");
    check_read("R6", 8'h22);
  endtask

  task automatic t_bad_sel;
    bus_write(8'h18, 8'h05);
    bus_write(8'h20, 8'hFF);
    check_pins("R7");
    check_read("R7", 8'h20);
    check_read("R7", 8'h1D);
    check_read("R7", 8'h18);
    bus_write(8'h18, 8'h00);
    check_read("R7", 8'h1E);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_write(8'h30, 8'hFF);
    bus_write(8'h1C, 8'hFF);
    bus_write(8'h24, 8'hFF);
    check_pins("R8");
    bus_read(8'h24, d);
    chk("R8", "unmapped read", int'(d), 0);
    @(negedge clk);
    chk("R8", "rd_valid idle", int'(rd_valid), 0);
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PW; i++)
        chk("R10", "legal code", int'(pin_mode[(p*PW+i)*MW +: MW] != 3'd7), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PW; i++)
        exp_code[p][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_zero_bits();
    t_last_wins();
    t_multi();
    t_port_sel();
    t_bad_sel();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule